// File: doc/BRIEF.md
# Power Management Event Register Block

This block is the event side of a power management controller. It sits behind a small I/O window of 64 byte offsets and holds four registers: an event status register, an event enable register, a sleep control register and a free-running power management timer. Platform logic signals wake and attention events into the status register. Software enables the events it wants, takes a level-sensitive interrupt while any enabled event is pending, and acknowledges each event by writing ones to the status register.

The timer advances once per cycle in which the timer tick input is high. The tick is meant to arrive at about 3.58 MHz. A timer overflow event is raised each time the count lands on an armed point. When software acknowledges that event, the next armed point moves to the following half-range boundary of the counter. A write to the control register with the sleep-go bit set asks the platform to power off or to suspend to RAM. The choice comes from the sleep type field. The go bit itself is never stored.

Register access uses a single-cycle request port. Read data is registered and is valid in the cycle after the request. An external I/O-enable input gates every access.

Top module: `pm_event_regs`

## Requirements
- R1: The register offsets are status 0x00, enable 0x02, control 0x04 and timer 0x08. A read request with io_en high returns the addressed register, zero-extended, on rd_data in the cycle after the request. rd_data holds its value when no read is made.
- R2: The timer count starts at 0 and advances by one, wrapping modulo 2^TMR_W, on each clock edge where tmr_tick is high. A read at 0x08 returns the count as it stood before that edge.
- R3: A status write clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R4: sci is high exactly when status AND enable has any of bit 10, bit 8, bit 5 or bit 0 set.
- R5: Status bit 0 sets on the edge where a tick moves the count onto the armed point. A status write that has bit 0 = 1 while status bit 0 is set re-arms the point to (count + 2^(TMR_W-1)) with the low TMR_W-1 bits cleared, modulo 2^TMR_W.
- R6: A control write stores every bit except bit 13. Bit 13 always reads back as 0.
- R7: A control write with bit 13 = 1 acts on the type in bits 12:10. Type 0 gives a one-cycle soft_off_p. Type 1 gives a one-cycle suspend_p and plat_rst_p, and sets status bits 15 and 8. Any other type does nothing. The pulses appear in the cycle after the write.
- R8: While io_en is low, a read returns all ones and a write changes no register and produces no pulse.
- R9: A read of any offset other than 0x00, 0x02, 0x04 or 0x08 returns all ones.
- R10: After reset, status, enable and control read 0, the timer reads 0, the armed point is all ones, and sci and all pulses are low.
- R11: Each bit of ev_set that is high sets the matching status bit at the next edge. Setting wins over a clear written in the same cycle, and the same holds for the overflow and suspend sets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| io_en | input | 1 | Access gate for the register window |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte offset inside the window |
| req_wdata | input | DATA_W | Write data (the low 16 bits are used) |
| rd_data | output | DATA_W | Registered read data |
| tmr_tick | input | 1 | Timer advance enable |
| ev_set | input | 16 | Event pulses that set status bits |
| sci | output | 1 | Level-sensitive event interrupt |
| soft_off_p | output | 1 | Soft power-off request pulse |
| suspend_p | output | 1 | Suspend-to-RAM request pulse |
| plat_rst_p | output | 1 | Platform reset request pulse |

## Verification
The bench builds the block with TMR_W = 8 and keeps DATA_W = 32 and ADDR_W = 6. With the 8-bit timer, the first overflow at the reset-armed point 0xFF takes a few hundred ticks. It also puts the counter wrap and both half-range re-arm cases within reach: a re-arm from the upper half lands on 0 and fires on the very next wrap, and a re-arm from the lower half lands on 0x80. Random traffic then exercises these cases many times against the bench's own register model.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

  localparam int REG_W = 16;
  typedef logic [REG_W-1:0] reg16_t;

  // Byte offsets inside the register window
  localparam logic [5:0] OFS_STS = 6'h00;
  localparam logic [5:0] OFS_EN  = 6'h02;
  localparam logic [5:0] OFS_CTL = 6'h04;
  localparam logic [5:0] OFS_TMR = 6'h08;

  // Status / enable bit positions
  localparam int B_TMR_OVF = 0;
  localparam int B_GLOBAL  = 5;
  localparam int B_BUTTON  = 8;
  localparam int B_ALARM   = 10;
  localparam int B_WAKE    = 15;

  // Control fields
  localparam int B_SLP_GO  = 13;
  localparam int SLP_TYP_L = 10;

  localparam logic [2:0] TYP_OFF = 3'd0;
  localparam logic [2:0] TYP_RAM = 3'd1;

  localparam reg16_t IRQ_MASK = reg16_t'((1 << B_ALARM) | (1 << B_BUTTON) |
                                         (1 << B_GLOBAL) | (1 << B_TMR_OVF));
  localparam reg16_t RAM_SET  = reg16_t'((1 << B_WAKE) | (1 << B_BUTTON));

endpackage

// File: rtl/pm_tmr.sv
module pm_tmr #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rearm,
  output logic [TMR_W-1:0] cnt_q,
  output logic             ovf_evt
);

  localparam logic [TMR_W-1:0] HALF  = {1'b1, {(TMR_W-1){1'b0}}};
  localparam logic [TMR_W-1:0] LOW_M = {1'b0, {(TMR_W-1){1'b1}}};

  logic [TMR_W-1:0] cnt_nxt;
  logic [TMR_W-1:0] arm_q, arm_nxt;
  logic [TMR_W-1:0] bumped;

  always_comb begin
    bumped  = cnt_q + HALF;
    cnt_nxt = tick ? cnt_q + 1'b1 : cnt_q;
    ovf_evt = tick && (cnt_nxt == arm_q);
    arm_nxt = rearm ? (bumped & ~LOW_M) : arm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      arm_q <= '1;
    end else begin
      cnt_q <= cnt_nxt;
      arm_q <= arm_nxt;
    end
  end

  // R2: the count steps by one per tick and holds otherwise
  p_tmr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == TMR_W'($past(cnt_q) + 1'b1)));
  p_tmr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
  // R5: a re-armed point always sits on a half-range boundary
  p_arm_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> ((arm_q & LOW_M) == '0));

endmodule

// File: rtl/pm_ctl.sv
module pm_ctl
  import pm_evt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en_we,
  input  logic   ctl_we,
  input  reg16_t wdata,
  output reg16_t en_q,
  output reg16_t ctl_q,
  output logic   ram_req,
  output logic   off_p,
  output logic   ram_p
);

  reg16_t     en_nxt, ctl_nxt;
  logic       go;
  logic [2:0] typ;
  logic       off_req;

  always_comb begin
    go      = ctl_we && wdata[B_SLP_GO];
    typ     = wdata[SLP_TYP_L +: 3];
    off_req = go && (typ == TYP_OFF);
    ram_req = go && (typ == TYP_RAM);
    en_nxt  = en_we ? wdata : en_q;
    ctl_nxt = ctl_q;
    if (ctl_we) begin
      ctl_nxt           = wdata;
      ctl_nxt[B_SLP_GO] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      ctl_q <= '0;
      off_p <= 1'b0;
      ram_p <= 1'b0;
    end else begin
      en_q  <= en_nxt;
      ctl_q <= ctl_nxt;
      off_p <= off_req;
      ram_p <= ram_req;
    end
  end

  // R7: at most one sleep request at a time, each only one cycle long
  p_one_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({off_p, ram_p}));
  p_off_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (off_p && !$past(off_req)) |-> 1'b0);
  p_ram_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_p && !$past(ram_req)) |-> 1'b0);

endmodule

// File: rtl/pm_sts.sv
module pm_sts
  import pm_evt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr_we,
  input  reg16_t clr_mask,
  input  reg16_t ev_set,
  input  logic   ovf_evt,
  input  logic   ram_req,
  input  reg16_t en_q,
  output reg16_t sts_q,
  output logic   rearm,
  output logic   sci
);

  reg16_t sts_nxt;
  reg16_t set_v;

  always_comb begin
    set_v = ev_set;
    if (ovf_evt) set_v[B_TMR_OVF] = 1'b1;
    if (ram_req) set_v = set_v | RAM_SET;
    sts_nxt = clr_we ? (sts_q & ~clr_mask) : sts_q;
    sts_nxt = sts_nxt | set_v;
    rearm   = clr_we && sts_q[B_TMR_OVF] && clr_mask[B_TMR_OVF];
    sci     = |(sts_q & en_q & IRQ_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_nxt;
  end

  // R3: bits written as one are clear after the write when nothing sets them
  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && (ev_set == '0) && !ovf_evt && !ram_req) |=>
      ((sts_q & $past(clr_mask)) == '0));
  // R11: an event input always leaves its bit set
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set != '0) |=> ((sts_q & $past(ev_set)) == $past(ev_set)));

endmodule

// File: rtl/pm_event_regs.sv
module pm_event_regs
  import pm_evt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int TMR_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tmr_tick,
  input  logic [15:0]       ev_set,
  output logic              sci,
  output logic              soft_off_p,
  output logic              suspend_p,
  output logic              plat_rst_p
);

  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STS);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_EN);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTL);
  localparam logic [ADDR_W-1:0] A_TMR = ADDR_W'(OFS_TMR);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // Request decode
  logic   acc, wr, rd;
  logic   sts_we, en_we, ctl_we;
  reg16_t wdata16;
  logic   unused_wdata;

  always_comb begin
    acc     = req_valid && io_en;
    wr      = acc && req_write;
    rd      = req_valid && !req_write;
    sts_we  = wr && (req_addr == A_STS);
    en_we   = wr && (req_addr == A_EN);
    ctl_we  = wr && (req_addr == A_CTL);
    wdata16 = req_wdata[REG_W-1:0];
  end
  assign unused_wdata = ^req_wdata[DATA_W-1:REG_W];

  // Sub-blocks
  logic [TMR_W-1:0] cnt_q;
  logic             ovf_evt, rearm, ram_req, off_p, ram_p;
  reg16_t           sts_q, en_q, ctl_q;

  pm_tmr #(.TMR_W(TMR_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick    (tmr_tick),
    .rearm   (rearm),
    .cnt_q   (cnt_q),
    .ovf_evt (ovf_evt)
  );

  pm_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en_we   (en_we),
    .ctl_we  (ctl_we),
    .wdata   (wdata16),
    .en_q    (en_q),
    .ctl_q   (ctl_q),
    .ram_req (ram_req),
    .off_p   (off_p),
    .ram_p   (ram_p)
  );

  pm_sts u_sts (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr_we   (sts_we),
    .clr_mask (wdata16),
    .ev_set   (ev_set),
    .ovf_evt  (ovf_evt),
    .ram_req  (ram_req),
    .en_q     (en_q),
    .sts_q    (sts_q),
    .rearm    (rearm),
    .sci      (sci)
  );

  // Registered read path
  logic [DATA_W-1:0] rd_nxt;

  always_comb begin
    rd_nxt = rd_data;
    if (rd) begin
      rd_nxt = '1;
      if (io_en) begin
        unique case (req_addr)
          A_STS:   rd_nxt = DATA_W'(sts_q);
          A_EN:    rd_nxt = DATA_W'(en_q);
          A_CTL:   rd_nxt = DATA_W'(ctl_q);
          A_TMR:   rd_nxt = DATA_W'(cnt_q);
          default: rd_nxt = '1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rd_data <= '0;
    else             rd_data <= rd_nxt;
  end

  assign soft_off_p = off_p;
  assign suspend_p  = ram_p;
  assign plat_rst_p = ram_p;

  // R8: gated reads float to all ones
  p_gate_rd_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !req_write && !io_en) |=> (rd_data == '1));
  // R8: gated writes raise no sleep request
  p_gate_wr_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!(req_valid && io_en)) |=> !(soft_off_p || suspend_p));
  // R9: holes in the window read as all ones
  p_hole_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !req_write && io_en && req_addr != A_STS &&
     req_addr != A_EN && req_addr != A_CTL && req_addr != A_TMR)
      |=> (rd_data == '1));

endmodule

// File: tb/pm_event_regs_tb.sv
module pm_event_regs_tb;

  localparam int CLK_P = 10;
  localparam int TW    = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic        tmr_tick = 1'b0;
  logic [15:0] ev_set = '0;
  logic        sci, soft_off_p, suspend_p, plat_rst_p;

  int checks = 0;
  int errors = 0;

  // bench model of the register state
  logic [15:0]   m_sts, m_en, m_ctl;
  logic [TW-1:0] m_cnt, m_arm;
  logic [31:0]   m_rd;
  logic          m_off, m_ram;

  always #(CLK_P/2) clk = ~clk;

  pm_event_regs #(.DATA_W(32), .ADDR_W(6), .TMR_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .io_en(io_en), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_data), .tmr_tick(tmr_tick), .ev_set(ev_set), .sci(sci),
    .soft_off_p(soft_off_p), .suspend_p(suspend_p), .plat_rst_p(plat_rst_p)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_expect(input logic [5:0] a, input logic ioe);
    if (!ioe) return 32'hFFFF_FFFF;
    case (a)
      6'h00:   return {16'h0, m_sts};
      6'h02:   return {16'h0, m_en};
      6'h04:   return {16'h0, m_ctl};
      6'h08:   return 32'(m_cnt);
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [TW-1:0] next_arm(input logic [TW-1:0] c);
    logic [TW-1:0] s;
    s = c + TW'(1 << (TW-1));
    return s & ~TW'((1 << (TW-1)) - 1);
  endfunction

  task automatic step(input logic v, input logic w, input logic [5:0] a,
                      input logic [31:0] d, input logic t,
                      input logic [15:0] ev, input logic ioe);
    logic        acc, ovf, go, n_off, n_ram;
    logic [15:0] n_sts, n_en, n_ctl;
    logic [TW-1:0] n_cnt, n_arm;
    logic [31:0] n_rd;
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    tmr_tick = t; ev_set = ev; io_en = ioe;
    acc   = v && ioe;
    n_cnt = t ? m_cnt + 1'b1 : m_cnt;
    ovf   = t && (n_cnt == m_arm);
    n_arm = m_arm;
    n_sts = m_sts;
    n_en  = m_en;
    n_ctl = m_ctl;
    n_rd  = m_rd;
    n_off = 1'b0;
    n_ram = 1'b0;
    if (v && !w) n_rd = rd_expect(a, ioe);
    if (acc && w) begin
      if (a == 6'h00) begin
        if (m_sts[0] && d[0]) n_arm = next_arm(m_cnt);
        n_sts = m_sts & ~d[15:0];
      end
      if (a == 6'h02) n_en = d[15:0];
      if (a == 6'h04) begin
        n_ctl = d[15:0] & 16'hDFFF;
        go = d[13];
        if (go && d[12:10] == 3'd0) n_off = 1'b1;
        if (go && d[12:10] == 3'd1) n_ram = 1'b1;
      end
    end
    n_sts = n_sts | ev;
    if (ovf)   n_sts[0] = 1'b1;
    if (n_ram) n_sts = n_sts | 16'h8100;
    @(posedge clk);
    #(CLK_P/4);
    m_sts = n_sts; m_en = n_en; m_ctl = n_ctl; m_cnt = n_cnt;
    m_arm = n_arm; m_rd = n_rd; m_off = n_off; m_ram = n_ram;
    chk("R4 sci level", {31'h0, sci}, {31'h0, |(m_sts & m_en & 16'h0521)});
    chk("R7 sleep pulses", {29'h0, soft_off_p, suspend_p, plat_rst_p},
        {29'h0, m_off, m_ram, m_ram});
    if (v && !w) chk("R1 read data", rd_data, m_rd);
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    step(1'b1, 1'b1, a, {16'h0, d}, 1'b0, 16'h0, 1'b1);
  endtask

  task automatic rd(input logic [5:0] a);
    step(1'b1, 1'b0, a, 32'h0, 1'b0, 16'h0, 1'b1);
  endtask

  task automatic idle(input logic t);
    step(1'b0, 1'b0, 6'h0, 32'h0, t, 16'h0, 1'b1);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5EED_0042;
    void'($urandom(seed));
    m_sts = '0; m_en = '0; m_ctl = '0; m_cnt = '0; m_arm = '1;
    m_rd = '0; m_off = 1'b0; m_ram = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: reset values
    chk("R10 sci after reset", {31'h0, sci}, 32'h0);
    rd(6'h00); chk("R10 status reset", rd_data, 32'h0);
    rd(6'h02); chk("R10 enable reset", rd_data, 32'h0);
    rd(6'h04); chk("R10 control reset", rd_data, 32'h0);
    rd(6'h08); chk("R10 timer reset", rd_data, 32'h0);

    // R11 + R4: alarm event raises sci once enabled
    wr(6'h02, 16'h0521);
    step(1'b0, 1'b0, 6'h0, 32'h0, 1'b0, 16'h0400, 1'b1);
    chk("R4 sci on alarm", {31'h0, sci}, 32'h1);
    // R3: zero write keeps bits, one write clears
    wr(6'h00, 16'h0000);
    rd(6'h00); chk("R3 zero write keeps", rd_data, 32'h0400);
    wr(6'h00, 16'h0400);
    chk("R3 clear drops sci", {31'h0, sci}, 32'h0);
    // R11: set beats same-cycle clear
    step(1'b1, 1'b1, 6'h00, 32'h0020, 1'b0, 16'h0020, 1'b1);
    rd(6'h00); chk("R11 set wins", rd_data, 32'h0020);
    wr(6'h00, 16'hFFFF);
    // R4: unmasked bit raises no interrupt
    step(1'b0, 1'b0, 6'h0, 32'h0, 1'b0, 16'h0002, 1'b1);
    chk("R4 masked bit", {31'h0, sci}, 32'h0);
    wr(6'h00, 16'hFFFF);

    // R6: go bit never stored
    wr(6'h04, 16'h1C05);
    rd(6'h04); chk("R6 control store", rd_data, 32'h1C05);
    // R7: type 0 power off
    wr(6'h04, 16'h2000);
    chk("R7 soft off pulse", {31'h0, soft_off_p}, 32'h1);
    idle(1'b0);
    chk("R7 soft off ends", {31'h0, soft_off_p}, 32'h0);
    rd(6'h04); chk("R6 go reads zero", rd_data, 32'h0);
    // R7: type 1 suspend
    wr(6'h04, 16'h2400);
    chk("R7 suspend pulse", {30'h0, suspend_p, plat_rst_p}, 32'h3);
    rd(6'h00); chk("R7 wake status", rd_data, 32'h8100);
    wr(6'h00, 16'hFFFF);
    // R7: other types inert
    wr(6'h04, 16'h2C00);
    chk("R7 other type", {29'h0, soft_off_p, suspend_p, plat_rst_p}, 32'h0);

    // R8: gated access
    step(1'b1, 1'b1, 6'h02, 32'h0000, 1'b0, 16'h0, 1'b0);
    step(1'b1, 1'b1, 6'h04, 32'h2000, 1'b0, 16'h0, 1'b0);
    chk("R8 gated sleep", {31'h0, soft_off_p}, 32'h0);
    step(1'b1, 1'b0, 6'h02, 32'h0, 1'b0, 16'h0, 1'b0);
    chk("R8 gated read", rd_data, 32'hFFFF_FFFF);
    rd(6'h02); chk("R8 enable kept", rd_data, 32'h0521);
    // R9: holes
    rd(6'h06); chk("R9 hole 0x06", rd_data, 32'hFFFF_FFFF);
    rd(6'h3F); chk("R9 hole 0x3F", rd_data, 32'hFFFF_FFFF);

    // R2/R5: run to reset-armed point 0xFF
    for (int i = 0; i < 254; i++) idle(1'b1);
    rd(6'h00); chk("R5 not yet", rd_data & 32'h1, 32'h0);
    idle(1'b1);
    rd(6'h00); chk("R5 overflow at FF", rd_data & 32'h1, 32'h1);
    rd(6'h08); chk("R2 timer value", rd_data, 32'h0000_00FF);
    // re-arm from upper half lands on 0: fires at wrap
    wr(6'h00, 16'h0001);
    idle(1'b1);
    chk("R5 wrap overflow sci", {31'h0, sci}, 32'h1);
    rd(6'h08); chk("R2 wrap", rd_data, 32'h0);
    // re-arm from 0 lands on 0x80
    wr(6'h00, 16'h0001);
    for (int i = 0; i < 127; i++) idle(1'b1);
    chk("R5 before 0x80", {31'h0, sci}, 32'h0);
    idle(1'b1);
    chk("R5 at 0x80", {31'h0, sci}, 32'h1);
    wr(6'h00, 16'hFFFF);

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      logic [5:0]  a;
      logic [31:0] d;
      logic [15:0] ev;
      logic [2:0]  pick;
      pick = 3'($urandom_range(0, 7));
      case (pick)
        3'd0, 3'd1: a = 6'h00;
        3'd2:       a = 6'h02;
        3'd3:       a = 6'h04;
        3'd4, 3'd5: a = 6'h08;
        default:    a = 6'($urandom);
      endcase
      d = $urandom;
      if (a == 6'h04 && d[13] && d[12:10] == 3'd0 && ($urandom_range(0, 3) != 0))
        d[13] = 1'b0;
      ev = ($urandom_range(0, 7) == 0) ? 16'($urandom) & 16'h0521 : 16'h0;
      step(($urandom_range(0, 2) != 0), $urandom_range(0, 1) == 1, a, d,
           ($urandom_range(0, 3) != 0), ev, ($urandom_range(0, 9) != 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule